// File: doc/BRIEF.md
# Save-Region Write-Back Scheduler

This block decides when the contents of a battery-backed save area should be copied out to removable storage. An upstream reader sweeps the save area again and again. For each sweep it marks the start, streams the bytes, and marks the end. The scheduler folds every sweep into a 16-bit checksum and compares it with the sweep before. When the checksum moves, the save area is marked as changed.

A changed save area does not cause an immediate write. The scheduler waits until the checksum has stayed put for a quiet interval. If the data never settles, a fallback interval measured from the first unsaved change forces a write anyway. Holding the console reset button long enough also forces a write. All time is counted in millisecond ticks. The block's only output is a one-cycle request to the storage controller, which answers with a completion pulse. Writes happen only on request, so the card sees one write per settled change instead of one per store.

Top module: `save_sched`

## Requirements
- R1: A sweep starts with `sweep_start`, takes bytes on `byte_valid` until `sweep_end`, and folds each byte as sum = rotate_left_by_1(sum) + byte, modulo 2^16, starting from zero. The fold depends on byte order, and bytes presented outside a sweep are ignored.
- R2: The first completed sweep after reset only records a baseline and never marks the area changed.
- R3: A completed sweep whose checksum differs from the previous sweep marks the area changed. An identical checksum leaves the state as it was.
- R4: With the area changed, a request is issued once QUIET_MS ticks pass with no further change. Every new change restarts that count from zero.
- R5: While the area stays changed, a request is forced once FORCE_MS ticks have passed since the first unsaved change, however often the data keeps changing.
- R6: Holding `reset_btn` high for HOLD_MS ticks raises one request. A shorter hold raises none, and a hold that continues past the threshold raises no further requests until the button is released.
- R7: `save_req` is high for exactly one cycle per request.
- R8: After a request, no new request is issued until `save_done` is seen. A long press during that time is dropped. A timer request that comes due during that time is issued once `save_done` arrives.
- R9: Issuing a request clears the changed flag and both timers, so a clean area raises no timer requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_start | input | 1 | Marks the start of a sweep; clears the running sum |
| byte_valid | input | 1 | A save-area byte is present on `byte_data` |
| byte_data | input | 8 | Save-area byte |
| sweep_end | input | 1 | Marks the end of a sweep; closes the checksum |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| reset_btn | input | 1 | Console reset button level, high while pressed |
| save_done | input | 1 | Storage controller has finished the requested write |
| save_req | output | 1 | One-cycle request to write the save area out |

## Verification
The hardest case to reach is the fallback save. It needs the area to keep changing at intervals shorter than the quiet interval for the whole fallback window, so the quiet timer restarts again and again while the fallback timer keeps counting. The bench builds this with a small configuration. It runs one-byte sweeps with a fresh value after every three ticks and counts request pulses just before and just after the fallback tick. A held request is reached in a similar way: the bench keeps back `save_done`, lets the quiet timer expire and a long press land, and then releases the completion.

// File: rtl/save_sched_pkg.sv
package save_sched_pkg;

    localparam int CSUM_W = 16;

    typedef logic [CSUM_W-1:0] csum_t;

    function automatic csum_t csum_fold(input csum_t acc, input logic [7:0] b);
        csum_t rot;
        rot = {acc[CSUM_W-2:0], acc[CSUM_W-1]};
        return rot + csum_t'(b);
    endfunction

endpackage

// File: rtl/sweep_checksum.sv
module sweep_checksum
    import save_sched_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sweep_start,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       sweep_end,
    output logic       changed
);

    typedef struct packed {
        logic  in_sweep;
        csum_t acc;
        csum_t base;
        logic  have_base;
        logic  change;
    } ck_state_t;

    ck_state_t st_d, st_q;
    csum_t     fin;

    always_comb begin
        st_d        = st_q;
        st_d.change = 1'b0;
        fin         = st_q.acc;
        if (sweep_start) begin
            st_d.in_sweep = 1'b1;
            st_d.acc      = '0;
        end else if (st_q.in_sweep) begin
            if (byte_valid) begin
                fin      = csum_fold(st_q.acc, byte_data);
                st_d.acc = fin;
            end
            if (sweep_end) begin
                st_d.in_sweep  = 1'b0;
                st_d.change    = st_q.have_base && (fin != st_q.base);
                st_d.base      = fin;
                st_d.have_base = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign changed = st_q.change;

    AST_BASELINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.change |-> $past(st_q.have_base)); // R2
    AST_CHANGE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.change |-> $past(sweep_end)); // R3

endmodule

// File: rtl/long_press.sv
module long_press #(
    parameter int HOLD_MS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_btn,
    input  logic tick_ms,
    output logic fire
);

    localparam int CW = $clog2(HOLD_MS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
        logic          pulse;
    } lp_state_t;

    lp_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!reset_btn) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else begin
            if (tick_ms && st_q.cnt != CW'(HOLD_MS))
                st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(HOLD_MS) && !st_q.done) begin
                st_d.pulse = 1'b1;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire = st_q.pulse;

    AST_PRESS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse); // R6
    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(HOLD_MS)); // R6

endmodule

// File: rtl/save_sched.sv
module save_sched #(
    parameter int QUIET_MS = 1000,
    parameter int FORCE_MS = 30000,
    parameter int HOLD_MS  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sweep_start,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       sweep_end,
    input  logic       tick_ms,
    input  logic       reset_btn,
    input  logic       save_done,
    output logic       save_req
);

    localparam int QW = $clog2(QUIET_MS + 1);
    localparam int FW = $clog2(FORCE_MS + 1);

    typedef struct packed {
        logic          dirty;
        logic [QW-1:0] quiet;
        logic [FW-1:0] force_t;
        logic          pending;
        logic          req;
    } sc_state_t;

    sc_state_t st_d, st_q;
    logic      changed;
    logic      press;
    logic      due;
    logic      issue;

    sweep_checksum u_ck (
        .clk         (clk),
        .rst_n       (rst_n),
        .sweep_start (sweep_start),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .sweep_end   (sweep_end),
        .changed     (changed)
    );

    long_press #(.HOLD_MS(HOLD_MS)) u_lp (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_btn (reset_btn),
        .tick_ms   (tick_ms),
        .fire      (press)
    );

    always_comb begin
        st_d  = st_q;
        due   = st_q.dirty && (st_q.quiet == QW'(QUIET_MS) ||
                               st_q.force_t == FW'(FORCE_MS));
        issue = !st_q.pending && (due || press);
        if (tick_ms && st_q.dirty) begin
            if (st_q.quiet != QW'(QUIET_MS))   st_d.quiet   = st_q.quiet + 1'b1;
            if (st_q.force_t != FW'(FORCE_MS)) st_d.force_t = st_q.force_t + 1'b1;
        end
        if (issue) begin
            st_d.dirty   = 1'b0;
            st_d.quiet   = '0;
            st_d.force_t = '0;
        end
        if (changed) begin
            st_d.dirty = 1'b1;
            st_d.quiet = '0;
            if (!st_q.dirty || issue) st_d.force_t = '0;
        end
        if (issue)          st_d.pending = 1'b1;
        else if (save_done) st_d.pending = 1'b0;
        st_d.req = issue;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign save_req = st_q.req;

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |=> !st_q.req); // R7
    AST_NO_REQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> !$past(st_q.pending)); // R8
    AST_REQ_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> st_q.pending); // R8
    AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.quiet <= QW'(QUIET_MS)); // R4
    AST_FORCE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.force_t <= FW'(FORCE_MS)); // R5
    AST_CLEAN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.dirty |-> st_q.quiet == '0 && st_q.force_t == '0); // R9

endmodule

// File: tb/save_sched_tb.sv
module save_sched_tb;

    localparam int QUIET = 4;
    localparam int FORCE = 10;
    localparam int HOLD  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sweep_start = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       sweep_end = 1'b0;
    logic       tick_ms = 1'b0;
    logic       reset_btn = 1'b0;
    logic       save_done = 1'b0;
    logic       save_req;

    int checks = 0;
    int errors = 0;
    int nreq = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    save_sched #(.QUIET_MS(QUIET), .FORCE_MS(FORCE), .HOLD_MS(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start), .byte_valid(byte_valid),
        .byte_data(byte_data), .sweep_end(sweep_end), .tick_ms(tick_ms),
        .reset_btn(reset_btn), .save_done(save_done), .save_req(save_req)
    );

    always @(negedge clk) begin
        cyc++;
        if (rst_n && save_req) nreq++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_ms = 1'b1;
            @(negedge clk); tick_ms = 1'b0;
            idle(3);
        end
    endtask

    task automatic sweep2(input logic [7:0] a, input logic [7:0] b, input int nb);
        @(negedge clk); sweep_start = 1'b1;
        @(negedge clk); sweep_start = 1'b0;
        byte_valid = 1'b1; byte_data = a;
        @(negedge clk);
        if (nb > 1) begin byte_data = b; @(negedge clk); end
        byte_valid = 1'b0; sweep_end = 1'b1;
        @(negedge clk); sweep_end = 1'b0;
        idle(3);
    endtask

    task automatic ack();
        @(negedge clk); save_done = 1'b1;
        @(negedge clk); save_done = 1'b0;
        idle(3);
    endtask

    initial begin
        int base;
        idle(3);
        check("R7 reset", int'(save_req), 0);
        rst_n = 1'b1;
        idle(2);

        // R2: baseline sweep only
        sweep2(8'h10, 8'h00, 1);
        ticks(FORCE + 2);
        check("R2 baseline", nreq, 0);

        // R3: identical sweep causes nothing
        sweep2(8'h10, 8'h00, 1);
        ticks(FORCE + 2);
        check("R3 same", nreq, 0);

        // R4: quiet expiry
        sweep2(8'h11, 8'h00, 1);
        ticks(QUIET - 1);
        check("R4 before quiet", nreq, 0);
        ticks(1);
        check("R4 at quiet", nreq, 1);
        ack();

        // R9: clean area stays silent
        ticks(FORCE + 2);
        check("R9 clean", nreq, 1);

        // R4: restart on further change
        sweep2(8'h12, 8'h00, 1);
        ticks(2);
        sweep2(8'h13, 8'h00, 1);
        ticks(QUIET - 1);
        check("R4 restart", nreq, 1);
        ticks(1);
        check("R4 after restart", nreq, 2);
        ack();

        // R5: fallback when changes keep coming
        sweep2(8'h20, 8'h00, 1);
        for (int g = 0; g < 3; g++) begin
            ticks(3);
            sweep2(8'(8'h21 + g), 8'h00, 1);
        end
        check("R5 before fallback", nreq, 2);
        ticks(1);
        check("R5 fallback", nreq, 3);
        ack();

        // R1: order matters (1,2 -> 4 ; 2,1 -> 5); stray bytes ignored
        sweep2(8'h01, 8'h02, 2);
        ticks(QUIET);
        base = nreq;
        check("R1 sweep a", base, 4);
        ack();
        sweep2(8'h02, 8'h01, 2);
        ticks(QUIET);
        check("R1 order", nreq, base + 1);
        ack();
        @(negedge clk); byte_valid = 1'b1; byte_data = 8'h55;
        @(negedge clk); byte_data = 8'hAA;
        @(negedge clk); byte_valid = 1'b0;
        sweep2(8'h02, 8'h01, 2);
        ticks(FORCE + 2);
        check("R1 stray ignored", nreq, base + 1);

        // R6: short press none, long press one
        reset_btn = 1'b1;
        ticks(HOLD - 1);
        reset_btn = 1'b0;
        idle(4);
        check("R6 short", nreq, base + 1);
        reset_btn = 1'b1;
        ticks(HOLD);
        check("R6 long", nreq, base + 2);
        ticks(4);
        check("R6 held", nreq, base + 2);
        reset_btn = 1'b0;
        idle(2);
        ack();

        // R8: pending blocks press, defers timer
        sweep2(8'h40, 8'h00, 1);
        ticks(QUIET);
        check("R8 first", nreq, base + 3);
        sweep2(8'h41, 8'h00, 1);
        ticks(QUIET + 1);
        reset_btn = 1'b1;
        ticks(HOLD + 1);
        reset_btn = 1'b0;
        idle(2);
        check("R8 blocked", nreq, base + 3);
        ack();
        check("R8 deferred", nreq, base + 4);
        ack();
        ticks(FORCE + 2);
        check("R8 press dropped", nreq, base + 4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule